// File: doc/BRIEF.md
# Parallel Port Mode and Control-Pin Controller

This block owns the operating mode of a printer-style parallel port and drives the printer-side control lines: strobe, autofd, selectin and init, the enable of an external data driver, and the eight data lines when the port is under direct software control. Three kinds of register write reach it over a simple write strobe with a select code. The first is a configuration word, holding the mode, enable, force and polarity bits. The second is a short control word, holding only the five control bits. The third is a wide control/data word, holding the data byte, the five control bits and an interrupt acknowledge.

A new mode is normally held back until the transfer engine reports that its handshake is idle. With the force bit it takes effect at once. An extension bit widens the 3-bit mode to a 4-bit code that adds one EPP read mode and three EPP write modes. Each status input passes through a two-flop synchronizer and its own inversion bit. The inputs are then packed, with the effective mode and two engine flags, into a 16-bit status word. A peripheral interrupt latch is set by an event input and cleared by software acknowledge.

Top module: `pport_ctl`

## Requirements
- R1: After reset the port is disabled and the mode is 0000. The pins are strobe=1, autofd=1, selectin=0 and init=1. The data output enable, data_o, irq_pend_o and status_o are all 0.
- R2: A configuration write (wr_sel=0) takes the mode from bits 2:0 and the extension from bit 3, and mode_o = {bit3, bits 2:0}. With the extension set, only 1000 (EPP read) and 1101/1110/1111 (EPP write 1/2/3) are legal. A write carrying any other extended code leaves the current and pending mode unchanged.
- R3: A legal configuration write with enable (bit 5) set, force (bit 4) clear and eng_idle_i low does not change mode_o. The mode is applied on the first clock with eng_idle_i high, and a later write replaces the waiting one. A write made while eng_idle_i is high takes effect on the write edge.
- R4: A legal write with force set takes effect on the write edge regardless of eng_idle_i, and it discards any waiting mode.
- R5: A configuration write with enable clear applies its mode at once and drops any waiting mode. While the port is disabled, the pins sit at the off levels of R6, the output enable sits at its inactive level, data_o is 0 and the interrupt latch is held clear.
- R6: In off mode (0111), strobe=1, autofd=1, selectin=0 and init=1, whatever the inversion bits. The output enable is inactive (equal to its inversion bit, cfg bit 15), and data_o is 0.
- R7: In manual mode (0000), each pin is the inverse of its control bit XOR its inversion bit. The inversion bits are cfg bits 11 (strobe), 12 (autofd), 13 (selectin) and 14 (init). data_o is the stored data byte, and the output enable is its control bit XOR cfg bit 15.
- R8: A wide control/data write (wr_sel=2) stores the data byte from bits 7:0 and the control bits from bits 20:16, in the order init (16), strb (17), autofd (18), seli (19), oe (20). A short control write (wr_sel=1) stores the same five bits from bits 4:0 and leaves the data byte and the interrupt latch unchanged.
- R9: In modes 0001 and 0010, init and autofd follow their control bits as in R7; in 0011 and 0100 only init does. Every other pin in these modes, and every pin in the EPP modes and in modes 0101–0110, sits at its inactive level (1 XOR its inversion bit). In all of these modes the output enable is inactive and data_o is 0.
- R10: Each status input is reported as its synchronized value XOR its inversion bit. The inversion bits are cfg bits 10 (perror), 9 (ack), 8 (busy), 7 (fault) and 6 (select). A pin change shows in status_o on the third clock edge after it.
- R11: status_o holds the mode's low three bits in 15:13 and the inverted inputs in 12:8, in the order perror, ack, busy, fault, select. It holds the extension bit in 7, zeros in 6:2, tr_rdy_i in 1 and dav_i in 0.
- R12: While the port is enabled, peri_irq_i high sets irq_pend_o. irq_pend_o then stays set until a wide control/data write with bit 24 set clears it; a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 configuration, 1 short control, 2 wide control/data |
| wr_data | input | 32 | Write data |
| eng_idle_i | input | 1 | Transfer engine handshake is idle |
| tr_rdy_i | input | 1 | Engine transmitter-ready flag |
| dav_i | input | 1 | Engine data-available flag |
| peri_irq_i | input | 1 | Peripheral interrupt event |
| perror_i | input | 1 | Paper-error pin |
| ack_i | input | 1 | Acknowledge pin |
| busy_i | input | 1 | Busy pin |
| fault_i | input | 1 | Fault pin |
| select_i | input | 1 | Select pin |
| strobe_n_o | output | 1 | Strobe pin |
| autofd_n_o | output | 1 | Auto-feed pin |
| selin_n_o | output | 1 | Select-in pin |
| init_n_o | output | 1 | Initialize pin |
| data_oe_o | output | 1 | External data driver enable |
| data_o | output | 8 | Data pins |
| mode_o | output | 4 | Effective 4-bit mode |
| status_o | output | 16 | Packed status word |
| irq_pend_o | output | 1 | Peripheral interrupt pending |

## Verification
The mode assertions assume that eng_idle_i reflects the engine truthfully. They also assume that a write whose select code is 3 never arrives. The stimulus therefore uses only select codes 0, 1 and 2, and it holds eng_idle_i steady across each write so that a deferral is cleanly separated from an application. The pin checks assume the pins are observed a cycle after the mode or enable settles, so the bench waits several cycles after each write. The status inputs are driven a full clock before they are sampled, because the synchronizer delay is taken as fixed.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int WR_W    = 32;
  localparam int DATA_W  = 8;
  localparam int N_IN    = 5;
  localparam int N_OUT   = 4;
  localparam int MODE_W  = 4;
  localparam int STAT_W  = 16;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_CD   = 2'd2;

  // configuration word field positions
  localparam int CF_EXT    = 3;
  localparam int CF_FORCE  = 4;
  localparam int CF_EN     = 5;
  localparam int CF_IINV_LO = 6;   // 6 select .. 10 perror
  localparam int CF_OINV_LO = 11;  // 11 strobe .. 14 init
  localparam int CF_OEINV  = 15;

  // wide control/data word
  localparam int CD_CTL_LO = 16;
  localparam int CD_IRQACK = 24;

  localparam logic [MODE_W-1:0] MD_MANUAL = 4'b0000;
  localparam logic [MODE_W-1:0] MD_OFF    = 4'b0111;

  // pin index order: 0 strobe, 1 autofd, 2 selectin, 3 init
  localparam logic [N_OUT-1:0] OFF_LVL = 4'b1011;

  typedef struct packed {
    logic oe;
    logic seli;
    logic autofd;
    logic strb;
    logic init;
  } ctl_t;

  function automatic logic code_legal(input logic [MODE_W-1:0] c);
    return !c[3] || (c[2:0] == 3'd0) || (c[2:0] >= 3'd5);
  endfunction

  // which pins follow their control bit for a given mode
  function automatic logic [N_OUT-1:0] follow_mask(input logic [MODE_W-1:0] c);
    case (c)
      4'd0:       return 4'b1111;
      4'd1, 4'd2: return 4'b1010;
      4'd3, 4'd4: return 4'b1000;
      default:    return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/pport_mode.sv
module pport_mode
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_code,
  input  logic              cfg_force,
  input  logic              cfg_en,
  input  logic              eng_idle,
  output logic [MODE_W-1:0] cur_mode,
  output logic              port_en
);
  logic [MODE_W-1:0] pend_mode;
  logic              pend_vld;
  logic              legal;

  assign legal = code_legal(cfg_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode  <= MD_MANUAL;
      pend_mode <= MD_MANUAL;
      pend_vld  <= 1'b0;
      port_en   <= 1'b0;
    end else if (cfg_wr) begin
      port_en <= cfg_en;
      if (legal) begin
        if (cfg_force || !cfg_en || eng_idle) begin
          cur_mode <= cfg_code;
          pend_vld <= 1'b0;
        end else begin
          pend_mode <= cfg_code;
          pend_vld  <= 1'b1;
        end
      end else if (!cfg_en) begin
        pend_vld <= 1'b0;
      end
    end else if (pend_vld && eng_idle) begin
      cur_mode <= pend_mode;
      pend_vld <= 1'b0;
    end
  end

  // R2: an illegal extended code never becomes the effective mode
  a_r2_legal_mode: assert property (@(posedge clk) disable iff (rst)
    cur_mode[3] |-> (cur_mode[2:0] == 3'd0 || cur_mode[2:0] >= 3'd5));

  // R3: while the engine is busy only a forced or disabling write moves the mode
  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    (!eng_idle && !(cfg_wr && (cfg_force || !cfg_en))) |=> $stable(cur_mode));

  // R4: a forced legal write lands on the next edge
  a_r4_force_now: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_force && code_legal(cfg_code)) |=> (cur_mode == $past(cfg_code)));
endmodule

// File: rtl/pport_insync.sv
module pport_insync
  import pport_pkg::*;
#(
  parameter int N      = N_IN,
  parameter int STAGES = 2
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins,
  input  logic [N-1:0] inv,
  output logic [N-1:0] lvl
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], pins[i]};
    end
    assign lvl[i] = sh[LAST] ^ inv[i];
  end
endmodule

// File: rtl/pport_ctlreg.sv
module pport_ctlreg
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              port_en,
  input  logic              irq_in,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] data,
  output logic              irq_pend
);
  logic wr_cd, wr_ctl, irq_ack;
  logic unused_hi;

  assign wr_cd   = wr_en && (wr_sel == SEL_CD);
  assign wr_ctl  = wr_en && (wr_sel == SEL_CTRL);
  assign irq_ack = wr_cd && wr_data[CD_IRQACK];
  assign unused_hi = ^{wr_data[WR_W-1:CD_IRQACK+1], wr_data[CD_IRQACK-1:CD_CTL_LO+5],
                       wr_data[CD_CTL_LO-1:DATA_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      data <= '0;
    end else if (wr_cd) begin
      ctl  <= ctl_t'(wr_data[CD_CTL_LO +: 5]);
      data <= wr_data[DATA_W-1:0];
    end else if (wr_ctl) begin
      ctl  <= ctl_t'(wr_data[4:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) irq_pend <= 1'b0;
    else if (irq_in)     irq_pend <= 1'b1;
    else if (irq_ack)    irq_pend <= 1'b0;
  end

  // R12: acknowledge without a new event clears the latch
  a_r12_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_in) |=> !irq_pend);

  // R8: the short control write leaves the data byte alone
  a_r8_short_keeps_data: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> $stable(data));
endmodule

// File: rtl/pport_pins.sv
module pport_pins
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic [MODE_W-1:0] mode,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] data,
  input  logic [N_OUT-1:0]  out_inv,
  input  logic              oe_inv,
  output logic [N_OUT-1:0]  pin_q,
  output logic              oe_q,
  output logic [DATA_W-1:0] dout_q
);
  logic [N_OUT-1:0] act, follow, pin_d;
  logic             quiet, manual;

  assign act    = {ctl.init, ctl.seli, ctl.autofd, ctl.strb};
  assign quiet  = !port_en || (mode == MD_OFF);
  assign manual = port_en && (mode == MD_MANUAL);
  assign follow = follow_mask(mode);

  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    always_comb begin
      if (quiet)          pin_d[i] = OFF_LVL[i];
      else if (follow[i]) pin_d[i] = ~act[i] ^ out_inv[i];
      else                pin_d[i] = ~out_inv[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= OFF_LVL;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      pin_q  <= pin_d;
      oe_q   <= manual ? (ctl.oe ^ oe_inv) : oe_inv;
      dout_q <= manual ? data : '0;
    end
  end

  // R6: off mode fixes the control lines
  a_r6_off_pins: assert property (@(posedge clk) disable iff (rst)
    ($past(port_en) && $past(mode) == MD_OFF) |-> (pin_q == OFF_LVL));

  // R5: a disabled port shows off levels and an idle driver
  a_r5_disabled_pins: assert property (@(posedge clk) disable iff (rst)
    !$past(port_en) |-> (pin_q == OFF_LVL && oe_q == $past(oe_inv) && dout_q == '0));
endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
  import pport_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [WR_W-1:0]     wr_data,
  input  logic                eng_idle_i,
  input  logic                tr_rdy_i,
  input  logic                dav_i,
  input  logic                peri_irq_i,
  input  logic                perror_i,
  input  logic                ack_i,
  input  logic                busy_i,
  input  logic                fault_i,
  input  logic                select_i,
  output logic                strobe_n_o,
  output logic                autofd_n_o,
  output logic                selin_n_o,
  output logic                init_n_o,
  output logic                data_oe_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [STAT_W-1:0]   status_o,
  output logic                irq_pend_o
);
  logic              cfg_wr;
  logic [N_IN-1:0]   in_inv, in_lvl;
  logic [N_OUT-1:0]  out_inv, pin_q;
  logic              oe_inv, port_en;
  logic [MODE_W-1:0] cur_mode;
  ctl_t              ctl;
  logic [DATA_W-1:0] data;

  assign cfg_wr = wr_en && (wr_sel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_inv  <= '0;
      out_inv <= '0;
      oe_inv  <= 1'b0;
    end else if (cfg_wr) begin
      in_inv  <= wr_data[CF_IINV_LO +: N_IN];
      out_inv <= wr_data[CF_OINV_LO +: N_OUT];
      oe_inv  <= wr_data[CF_OEINV];
    end
  end

  pport_mode u_mode (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .cfg_code({wr_data[CF_EXT], wr_data[2:0]}),
    .cfg_force(wr_data[CF_FORCE]), .cfg_en(wr_data[CF_EN]),
    .eng_idle(eng_idle_i), .cur_mode(cur_mode), .port_en(port_en)
  );

  pport_insync #(.N(N_IN), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .pins({perror_i, ack_i, busy_i, fault_i, select_i}),
    .inv(in_inv), .lvl(in_lvl)
  );

  pport_ctlreg u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .port_en(port_en), .irq_in(peri_irq_i), .ctl(ctl), .data(data),
    .irq_pend(irq_pend_o)
  );

  pport_pins u_pins (
    .clk(clk), .rst(rst), .port_en(port_en), .mode(cur_mode), .ctl(ctl),
    .data(data), .out_inv(out_inv), .oe_inv(oe_inv),
    .pin_q(pin_q), .oe_q(data_oe_o), .dout_q(data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= {cur_mode[2:0], in_lvl, cur_mode[3], 5'b0, tr_rdy_i, dav_i};
  end

  assign strobe_n_o = pin_q[0];
  assign autofd_n_o = pin_q[1];
  assign selin_n_o  = pin_q[2];
  assign init_n_o   = pin_q[3];
  assign mode_o     = cur_mode;

  // R11: status mode field follows the effective mode one edge later
  a_r11_status_mode: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o[15:13] == $past(cur_mode[2:0]) && status_o[7] == $past(cur_mode[3])
              && status_o[6:2] == 5'b0));
endmodule

// File: tb/pport_ctl_bench.sv
`timescale 1ns/1ps
module pport_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        eng_idle_i = 1'b1, tr_rdy_i = 1'b0, dav_i = 1'b0, peri_irq_i = 1'b0;
  logic        perror_i = 1'b0, ack_i = 1'b0, busy_i = 1'b0, fault_i = 1'b0, select_i = 1'b0;
  logic        strobe_n_o, autofd_n_o, selin_n_o, init_n_o, data_oe_o, irq_pend_o;
  logic [7:0]  data_o;
  logic [3:0]  mode_o;
  logic [15:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pport_ctl u_pport_ctl (.*);

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] dat;
    logic [3:0]  mode;
    logic [3:0]  pins;   // {strobe, autofd, selin, init}
    logic        oe;
    logic [7:0]  dout;
  } vec_t;

  // R6 R7 R8 R9 R2 pin and mode table, engine idle throughout
  localparam int NV = 10;
  localparam vec_t VT [0:NV-1] = '{
    '{2'd0, 32'h0000_0020, 4'd0,  4'b1111, 1'b0, 8'h00},
    '{2'd2, 32'h0003_00A5, 4'd0,  4'b0110, 1'b0, 8'hA5},
    '{2'd1, 32'h0000_001C, 4'd0,  4'b1001, 1'b1, 8'hA5},
    '{2'd0, 32'h0000_8820, 4'd0,  4'b0001, 1'b0, 8'hA5},
    '{2'd0, 32'h0000_0027, 4'd7,  4'b1101, 1'b0, 8'h00},
    '{2'd0, 32'h0000_0021, 4'd1,  4'b1011, 1'b0, 8'h00},
    '{2'd0, 32'h0000_0028, 4'd8,  4'b1111, 1'b0, 8'h00},
    '{2'd0, 32'h0000_4023, 4'd3,  4'b1110, 1'b0, 8'h00},
    '{2'd0, 32'h0000_002E, 4'd14, 4'b1111, 1'b0, 8'h00},
    '{2'd0, 32'h0000_F827, 4'd7,  4'b1101, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] pins_now();
    return {strobe_n_o, autofd_n_o, selin_n_o, init_n_o};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    chk("R1 mode", mode_o, 4'd0);
    chk("R1 pins", pins_now(), 4'b1101);
    chk("R1 oe/data/irq", {data_oe_o, data_o, irq_pend_o}, 10'd0);
    chk("R1 status", status_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(VT[i].sel, VT[i].dat);
      settle(3);
      checks++;
      if (mode_o !== VT[i].mode || pins_now() !== VT[i].pins ||
          data_oe_o !== VT[i].oe || data_o !== VT[i].dout) begin
        errors++;
        $display("FAIL vector %0d (R2 R6 R7 R8 R9): actual %h/%b/%b/%h expected %h/%b/%b/%h",
                 i, mode_o, pins_now(), data_oe_o, data_o,
                 VT[i].mode, VT[i].pins, VT[i].oe, VT[i].dout);
      end
    end

    // R10 R11 status packing with perror inverted
    perror_i = 1'b1; ack_i = 1'b1; busy_i = 1'b0; fault_i = 1'b1; select_i = 1'b0;
    tr_rdy_i = 1'b1; dav_i = 1'b0;
    wr(2'd0, 32'h0000_0420);
    settle(4);
    chk("R10 R11 status manual", status_o, 16'h0A02);
    wr(2'd0, 32'h0000_042D);
    settle(3);
    chk("R2 EPP write 1 code", mode_o, 4'b1101);
    chk("R11 status EPP", status_o, 16'hAA82);
    busy_i = 1'b1;
    settle(2);
    chk("R10 sync not yet", status_o[10], 1'b0);
    settle(1);
    chk("R10 sync third edge", status_o, 16'hAE82);

    // R3 deferral
    wr(2'd0, 32'h0000_0020);
    settle(2);
    eng_idle_i = 1'b0;
    wr(2'd0, 32'h0000_0021);
    settle(4);
    chk("R3 held while busy", mode_o, 4'd0);
    wr(2'd0, 32'h0000_0023);
    settle(4);
    chk("R3 replaced still held", mode_o, 4'd0);
    eng_idle_i = 1'b1;
    settle(2);
    chk("R3 applied on idle", mode_o, 4'd3);

    // R4 force
    eng_idle_i = 1'b0;
    wr(2'd0, 32'h0000_0025);
    wr(2'd0, 32'h0000_0031);
    chk("R4 forced immediate", mode_o, 4'd1);
    eng_idle_i = 1'b1;
    settle(3);
    chk("R4 pending discarded", mode_o, 4'd1);

    // R2 illegal extended codes rejected
    wr(2'd0, 32'h0000_0029);
    settle(2);
    chk("R2 illegal 1001", mode_o, 4'd1);
    wr(2'd0, 32'h0000_002C);
    settle(2);
    chk("R2 illegal 1100", mode_o, 4'd1);

    // R12 interrupt latch
    wr(2'd0, 32'h0000_0020);
    wr(2'd2, 32'h0000_005A);
    @(negedge clk); peri_irq_i = 1'b1;
    @(negedge clk); peri_irq_i = 1'b0;
    settle(2);
    chk("R12 latch set", irq_pend_o, 1'b1);
    wr(2'd1, 32'h0000_0000);
    settle(2);
    chk("R12 short write keeps latch", irq_pend_o, 1'b1);
    chk("R8 short write keeps data", data_o, 8'h5A);
    wr(2'd2, 32'h0000_005A);
    settle(2);
    chk("R12 no ack keeps latch", irq_pend_o, 1'b1);
    wr(2'd2, 32'h0100_005A);
    settle(2);
    chk("R12 ack clears", irq_pend_o, 1'b0);
    @(negedge clk); peri_irq_i = 1'b1;
    wr(2'd2, 32'h0100_005A);
    peri_irq_i = 1'b0;
    settle(2);
    chk("R12 set wins over ack", irq_pend_o, 1'b1);

    // R5 disable with a waiting mode and a pending interrupt
    wr(2'd2, 32'h0003_00A5);
    eng_idle_i = 1'b0;
    wr(2'd0, 32'h0000_0023);
    wr(2'd0, 32'h0000_0005);
    chk("R5 disable write immediate", mode_o, 4'd5);
    settle(3);
    chk("R5 disabled pins", pins_now(), 4'b1101);
    chk("R5 disabled oe/data/irq", {data_oe_o, data_o, irq_pend_o}, 10'd0);
    eng_idle_i = 1'b1;
    settle(3);
    chk("R5 pending dropped", mode_o, 4'd5);
    wr(2'd0, 32'h0000_0020);
    settle(3);
    chk("R5 re-enabled manual pins", pins_now(), 4'b0110);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule